// File: doc/BRIEF.md
# Cache Maintenance Command Queue Frontend

This block sits between several CPUs and a single cache maintenance engine. Each CPU posts a maintenance command through a small register window. It writes a shared mode word, and for address-range work also a start address and a byte count. It then reads its private registration status to learn whether the command was taken. The first CPU to write the mode word gains exclusive use of the shared command registers. Other CPUs that try to register during that time are refused. The right is given back when the owning CPU reads its own registration status, and that same read pushes the command into an ordered queue.

A stub engine drains the queue one command at a time and spends a fixed number of cycles on each. The command it finishes is shown on the execution ports. When a finished command asked for notification, the issuing CPU's private done flag is raised, and the CPU clears the flag by writing a one to it. A separate primitive register offers a drain barrier: after the sync code has been written there, a read of that register is held off until the queue and the engine are both empty.

Top module: `cmq_frontend`

## Requirements
- R1: The register select codes are: mode 0, address 1, size 2, registration status 3. A mode write while no CPU holds the access right gives the right to the writer. The owner's later read of registration status returns 0 when the queue has room and queues the command. Mode bits [1:0] carry the operation (0 invalidate, 1 clean, 2 flush), bit 15 asks for notification, and bits [18:17] are the scope.
- R2: While one CPU holds the right, a mode, address or size write from any other CPU sets bit 0 (failure) of that other CPU's registration status, and leaves the owner's staged command untouched.
- R3: A registration status read by the owner returns the status and releases the right in the same transfer. The same read by a CPU that does not own the right releases nothing.
- R4: If the queue already holds QDEPTH entries when the owner reads its registration status, the read returns bit 1 (full) set, the command is dropped, and the right is still released.
- R5: A command whose scope field is nonzero covers the whole cache and reaches the engine with address and size both zero, whatever was written to those registers. Scope 0 passes the staged address and size unchanged.
- R6: Commands reach the execution ports one at a time in acceptance order. Each one is shown for a single cycle. While the queue stays non-empty, consecutive commands are EXEC_CYCLES+1 cycles apart.
- R7: The done status (select 4) reads bit 2 set once a command from that CPU with the notify bit has finished. Commands without the notify bit, and commands from other CPUs, leave it clear.
- R8: A done-status write with bit 2 set clears only the writer's flag. A write with bit 2 clear changes nothing.
- R9: Writing exactly 8 to the primitive register (select 5) arms a barrier. A following read of that register holds bus_ready low until the queue and the engine are empty, then returns the stored value. Any other written value arms nothing, and the read completes at once.
- R10: After reset no CPU holds the right, every registration and done status reads 0, bus_ready is high and exec_valid is low.
- R11: A CPU whose status shows a failure gets it cleared when it later wins the access right with a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_cpu | input | CPU_W | Identity of the requesting CPU |
| bus_sel | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Transfer completes on this edge when high with bus_valid |
| bus_rdata | output | 32 | Read data, valid while bus_valid and bus_ready are high |
| exec_valid | output | 1 | One-cycle pulse as a command finishes |
| exec_cpu | output | 8 | CPU that issued the finishing command |
| exec_op | output | 2 | Operation code of the finishing command |
| exec_whole | output | 1 | Finishing command covers the whole cache |
| exec_notify | output | 1 | Finishing command requested notification |
| exec_addr | output | 32 | Start address of the finishing command |
| exec_size | output | 32 | Byte count of the finishing command |

## Verification
A stuck or wrongly assigned owner shows up at once: either a second CPU's registration status reads a failure it should not have, or the owner's accepted command never appears on the execution ports. A queue pointer or occupancy error shows within one engine period. Commands then come out in the wrong order, twice, or with a full flag raised against a queue that has room. A lost barrier arm shows as a primitive read that returns before the pending command has been executed.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    localparam int WORD_W      = 32;
    localparam int SCOPE_LSB   = 17;
    localparam int NOTIFY_BIT  = 15;
    localparam int ST_FAIL_BIT = 0;
    localparam int ST_FULL_BIT = 1;
    localparam int ST_DONE_BIT = 2;
    localparam logic [WORD_W-1:0] SYNC_CODE = 32'd8;

    typedef enum logic [2:0] {
        SEL_MODE   = 3'd0,
        SEL_ADDR   = 3'd1,
        SEL_SIZE   = 3'd2,
        SEL_REGST  = 3'd3,
        SEL_DONEST = 3'd4,
        SEL_PRIM   = 3'd5
    } sel_e;

    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef struct packed {
        logic [7:0]        cpu;
        op_e               op;
        logic              whole;
        logic              notify;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] size;
    } cmd_t;

    // Turn the staged register contents into one queue entry.
    function automatic cmd_t build_cmd(input logic [WORD_W-1:0] mode,
                                       input logic [WORD_W-1:0] addr,
                                       input logic [WORD_W-1:0] size,
                                       input logic [7:0]        cpu);
        cmd_t c;
        c.cpu    = cpu;
        c.op     = op_e'(mode[1:0]);
        c.whole  = (mode[SCOPE_LSB +: 2] != 2'd0);
        c.notify = mode[NOTIFY_BIT];
        c.addr   = c.whole ? '0 : addr;
        c.size   = c.whole ? '0 : size;
        return c;
    endfunction

endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid = (cnt != '0);
    assign full  = (cnt == CW'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/cmq_engine.sv
module cmq_engine
    import cmq_pkg::*;
#(
    parameter int EXEC_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  cmd_t in_cmd,
    output logic pop,
    output logic busy,
    output logic done_valid,
    output cmd_t done_cmd
);
    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

    logic             active;
    logic [CNT_W-1:0] cnt;
    cmd_t             cur;

    assign pop        = !active && in_valid;
    assign busy       = active;
    assign done_valid = active && (cnt == '0);
    assign done_cmd   = cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            cur    <= '0;
        end else if (pop) begin
            active <= 1'b1;
            cnt    <= CNT_W'(EXEC_CYCLES - 1);
            cur    <= in_cmd;
        end else if (active) begin
            if (cnt == '0) active <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cmq_access.sv
module cmq_access
    import cmq_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int CPU_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_mode,
    input  logic              wr_addr,
    input  logic              wr_size,
    input  logic              rd_stat,
    input  logic [CPU_W-1:0]  cpu,
    input  logic [WORD_W-1:0] wdata,
    input  logic              q_full,
    output logic              push,
    output cmd_t              push_cmd,
    output logic [WORD_W-1:0] stat_rdata,
    output logic [WORD_W-1:0] mode_q,
    output logic [WORD_W-1:0] addr_q,
    output logic [WORD_W-1:0] size_q,
    output logic              own_v,
    output logic [CPU_W-1:0]  own_id,
    output logic              own_rel
);
    logic [1:0] regst [NCPU];
    logic       hit, other;
    logic [1:0] stat_val;

    assign hit     = own_v && (own_id == cpu);
    assign other   = own_v && !hit;
    assign own_rel = rd_stat && hit;
    assign push    = own_rel && !q_full;

    // Full is judged at the moment of the releasing read.
    always_comb begin
        stat_val = regst[cpu];
        if (hit && q_full) stat_val[ST_FULL_BIT] = 1'b1;
    end

    assign stat_rdata = {{(WORD_W-2){1'b0}}, stat_val};
    assign push_cmd   = build_cmd(mode_q, addr_q, size_q, 8'(own_id));

    always_ff @(posedge clk) begin
        if (rst) begin
            own_v  <= 1'b0;
            own_id <= '0;
            mode_q <= '0;
            addr_q <= '0;
            size_q <= '0;
            for (int i = 0; i < NCPU; i++) regst[i] <= '0;
        end else begin
            if (wr_mode) begin
                if (!own_v) begin
                    own_v      <= 1'b1;
                    own_id     <= cpu;
                    mode_q     <= wdata;
                    addr_q     <= '0;
                    size_q     <= '0;
                    regst[cpu] <= '0;
                end else if (hit) begin
                    mode_q <= wdata;
                end else begin
                    regst[cpu][ST_FAIL_BIT] <= 1'b1;
                end
            end
            if (wr_addr) begin
                if (hit)        addr_q <= wdata;
                else if (other) regst[cpu][ST_FAIL_BIT] <= 1'b1;
            end
            if (wr_size) begin
                if (hit)        size_q <= wdata;
                else if (other) regst[cpu][ST_FAIL_BIT] <= 1'b1;
            end
            if (own_rel) begin
                own_v      <= 1'b0;
                regst[cpu] <= stat_val;
            end
        end
    end
endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
    import cmq_pkg::*;
#(
    parameter int NCPU        = 4,
    parameter int QDEPTH      = 4,
    parameter int EXEC_CYCLES = 32,
    localparam int CPU_W      = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [CPU_W-1:0]  bus_cpu,
    input  logic [2:0]        bus_sel,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              exec_valid,
    output logic [7:0]        exec_cpu,
    output logic [1:0]        exec_op,
    output logic              exec_whole,
    output logic              exec_notify,
    output logic [WORD_W-1:0] exec_addr,
    output logic [WORD_W-1:0] exec_size
);
    localparam int CMD_W = $bits(cmd_t);

    sel_e              sel;
    logic              acc, acc_wr, acc_rd;
    logic              q_push, q_pop, q_valid, q_full;
    cmd_t              push_cmd, head_cmd, fin_cmd;
    logic [CMD_W-1:0]  q_dout;
    logic              eng_busy, eng_done;
    logic [WORD_W-1:0] stat_rdata, mode_q, addr_q, size_q;
    logic              own_v, own_rel;
    logic [CPU_W-1:0]  own_id;
    logic [NCPU-1:0]   done_q;
    logic [WORD_W-1:0] prim_q;
    logic              sync_arm;
    logic              drain_busy;

    assign sel    = sel_e'(bus_sel);
    assign acc    = bus_valid && bus_ready;
    assign acc_wr = acc && bus_write;
    assign acc_rd = acc && !bus_write;

    cmq_access #(.NCPU(NCPU), .CPU_W(CPU_W)) u_access (
        .clk        (clk),
        .rst        (rst),
        .wr_mode    (acc_wr && sel == SEL_MODE),
        .wr_addr    (acc_wr && sel == SEL_ADDR),
        .wr_size    (acc_wr && sel == SEL_SIZE),
        .rd_stat    (acc_rd && sel == SEL_REGST),
        .cpu        (bus_cpu),
        .wdata      (bus_wdata),
        .q_full     (q_full),
        .push       (q_push),
        .push_cmd   (push_cmd),
        .stat_rdata (stat_rdata),
        .mode_q     (mode_q),
        .addr_q     (addr_q),
        .size_q     (size_q),
        .own_v      (own_v),
        .own_id     (own_id),
        .own_rel    (own_rel)
    );

    cmq_fifo #(.W(CMD_W), .DEPTH(QDEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (q_push),
        .din   (push_cmd),
        .pop   (q_pop),
        .dout  (q_dout),
        .valid (q_valid),
        .full  (q_full)
    );

    assign head_cmd = cmd_t'(q_dout);

    cmq_engine #(.EXEC_CYCLES(EXEC_CYCLES)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (q_valid),
        .in_cmd     (head_cmd),
        .pop        (q_pop),
        .busy       (eng_busy),
        .done_valid (eng_done),
        .done_cmd   (fin_cmd)
    );

    assign exec_valid  = eng_done;
    assign exec_cpu    = fin_cmd.cpu;
    assign exec_op     = fin_cmd.op;
    assign exec_whole  = fin_cmd.whole;
    assign exec_notify = fin_cmd.notify;
    assign exec_addr   = fin_cmd.addr;
    assign exec_size   = fin_cmd.size;

    // Per-CPU completion flags: a finish sets, the owner's write-one clears.
    for (genvar g = 0; g < NCPU; g++) begin : g_done
        always_ff @(posedge clk) begin
            if (rst)
                done_q[g] <= 1'b0;
            else if (eng_done && fin_cmd.notify && fin_cmd.cpu == 8'(g))
                done_q[g] <= 1'b1;
            else if (acc_wr && sel == SEL_DONEST && bus_cpu == CPU_W'(g)
                     && bus_wdata[ST_DONE_BIT])
                done_q[g] <= 1'b0;
        end
    end

    // Drain barrier on the primitive register.
    assign drain_busy = q_valid || eng_busy;
    assign bus_ready  = !(bus_valid && !bus_write && sel == SEL_PRIM
                          && sync_arm && drain_busy);

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q   <= '0;
            sync_arm <= 1'b0;
        end else if (acc_wr && sel == SEL_PRIM) begin
            prim_q   <= bus_wdata;
            sync_arm <= (bus_wdata == SYNC_CODE);
        end else if (acc_rd && sel == SEL_PRIM) begin
            sync_arm <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_MODE:   bus_rdata = mode_q;
            SEL_ADDR:   bus_rdata = addr_q;
            SEL_SIZE:   bus_rdata = size_q;
            SEL_REGST:  bus_rdata = stat_rdata;
            SEL_DONEST: bus_rdata[ST_DONE_BIT] = done_q[bus_cpu];
            SEL_PRIM:   bus_rdata = prim_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmq_frontend_chk.sv
module cmq_frontend_chk
    import cmq_pkg::*;
#(
    parameter int CPU_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [2:0]       bus_sel,
    input logic             bus_ready,
    input logic             q_push,
    input logic             q_full,
    input logic             q_valid,
    input logic             eng_busy,
    input logic             own_v,
    input logic [CPU_W-1:0] own_id,
    input logic             own_rel,
    input logic             exec_valid,
    input logic             sync_arm
);
    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
        !(q_push && q_full)); // R4

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (rst)
        (own_v && !own_rel) |=> (own_v && $stable(own_id))); // R3

    AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        exec_valid |=> !exec_valid); // R6

    AST_IDLE_NO_EXEC: assert property (@(posedge clk) disable iff (rst)
        !eng_busy |-> !exec_valid); // R6

    AST_STALL_ONLY_PRIM_READ: assert property (@(posedge clk) disable iff (rst)
        !bus_ready |-> (bus_valid && !bus_write && bus_sel == SEL_PRIM)); // R9

    AST_SYNC_DRAINED: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_ready && !bus_write && bus_sel == SEL_PRIM && sync_arm)
        |-> (!q_valid && !eng_busy)); // R9
endmodule

bind cmq_frontend cmq_frontend_chk #(.CPU_W(CPU_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_sel    (bus_sel),
    .bus_ready  (bus_ready),
    .q_push     (q_push),
    .q_full     (q_full),
    .q_valid    (q_valid),
    .eng_busy   (eng_busy),
    .own_v      (own_v),
    .own_id     (own_id),
    .own_rel    (own_rel),
    .exec_valid (exec_valid),
    .sync_arm   (sync_arm)
);

// File: tb/cmq_frontend_bench.sv
`timescale 1ns/1ps
module cmq_frontend_bench;
    localparam int NCPU  = 4;
    localparam int DEPTH = 4;
    localparam int EXEC  = 32;
    localparam int CPUW  = 2;

    localparam logic [2:0] S_MODE = 3'd0, S_ADDR = 3'd1, S_SIZE = 3'd2,
                           S_REGST = 3'd3, S_DONE = 3'd4, S_PRIM = 3'd5;

    typedef struct packed {
        logic        wr;
        logic [1:0]  cpu;
        logic [2:0]  sel;
        logic [31:0] data;   // write data, or expected read data
        logic        chk;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 2'd0, S_MODE,  32'h0000_8002, 1'b0}, // R1 cpu0 grant, flush range notify
        '{1'b1, 2'd0, S_ADDR,  32'h0000_1000, 1'b0}, // R1
        '{1'b1, 2'd0, S_SIZE,  32'h0000_0080, 1'b0}, // R1
        '{1'b1, 2'd1, S_MODE,  32'h0002_8001, 1'b0}, // R2 refused
        '{1'b1, 2'd1, S_ADDR,  32'h0000_2000, 1'b0}, // R2 refused
        '{1'b0, 2'd1, S_REGST, 32'h0000_0001, 1'b1}, // R2 fail bit, R3 no release
        '{1'b0, 2'd0, S_REGST, 32'h0000_0000, 1'b1}, // R1 R3 accepted and released
        '{1'b1, 2'd1, S_MODE,  32'h0002_8001, 1'b0}, // R11 cpu1 now wins
        '{1'b1, 2'd1, S_ADDR,  32'hDEAD_0000, 1'b0}, // R5 ignored for whole
        '{1'b1, 2'd1, S_SIZE,  32'h0000_0100, 1'b0}, // R5
        '{1'b0, 2'd1, S_REGST, 32'h0000_0000, 1'b1}, // R11 fail cleared
        '{1'b0, 2'd1, S_REGST, 32'h0000_0000, 1'b1}, // R3 stored status
        '{1'b0, 2'd0, S_DONE,  32'h0000_0000, 1'b1}  // R7 not finished yet
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [CPUW-1:0] bus_cpu = '0;
    logic [2:0]      bus_sel = '0;
    logic [31:0]     bus_wdata = '0;
    logic            bus_ready;
    logic [31:0]     bus_rdata;
    logic            exec_valid;
    logic [7:0]      exec_cpu;
    logic [1:0]      exec_op;
    logic            exec_whole;
    logic            exec_notify;
    logic [31:0]     exec_addr;
    logic [31:0]     exec_size;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int exec_n = 0;
    int   log_cyc  [32];
    logic [7:0]  log_cpu  [32];
    logic [1:0]  log_op   [32];
    logic        log_whole[32];
    logic [31:0] log_addr [32];
    logic [31:0] log_size [32];

    cmq_frontend #(.NCPU(NCPU), .QDEPTH(DEPTH), .EXEC_CYCLES(EXEC)) u_cmq_frontend (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_cpu(bus_cpu),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .exec_valid(exec_valid), .exec_cpu(exec_cpu), .exec_op(exec_op),
        .exec_whole(exec_whole), .exec_notify(exec_notify),
        .exec_addr(exec_addr), .exec_size(exec_size)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && exec_valid && exec_n < 32) begin
            log_cyc[exec_n]   = cyc;
            log_cpu[exec_n]   = exec_cpu;
            log_op[exec_n]    = exec_op;
            log_whole[exec_n] = exec_whole;
            log_addr[exec_n]  = exec_addr;
            log_size[exec_n]  = exec_size;
            exec_n = exec_n + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [1:0] cpu, input logic [2:0] sel,
                          input logic [31:0] wd, output logic [31:0] rd, output int waited);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_cpu   = cpu;
        bus_sel   = sel;
        bus_wdata = wd;
        waited    = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
            waited++;
        end
        rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] cpu, input logic [2:0] sel, input logic [31:0] wd);
        logic [31:0] rd;
        int w;
        bus_op(1'b1, cpu, sel, wd, rd, w);
    endtask

    task automatic rd_reg(input logic [1:0] cpu, input logic [2:0] sel, output logic [31:0] rd);
        int w;
        bus_op(1'b0, cpu, sel, 32'h0, rd, w);
    endtask

    task automatic wait_exec(input int n);
        for (int k = 0; k < 4000 && exec_n < n; k++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w;
        int n0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset state
        @(negedge clk);
        check("R10 ready", {31'b0, bus_ready}, 32'h1);
        check("R10 exec_valid", {31'b0, exec_valid}, 32'h0);
        rd_reg(2'd0, S_REGST, rd); check("R10 regst cpu0", rd, 32'h0);
        rd_reg(2'd3, S_DONE, rd);  check("R10 done cpu3", rd, 32'h0);

        // Table walk: R1 R2 R3 R5 R7 R11
        for (int v = 0; v < NVEC; v++) begin
            bus_op(VEC[v].wr, VEC[v].cpu, VEC[v].sel, VEC[v].data, rd, w);
            if (VEC[v].chk) begin
                checks++;
                if (rd !== VEC[v].data) begin
                    fails++;
                    $display("FAIL table vector %0d (R1/R2/R3/R7/R11): actual %h expected %h",
                             v, rd, VEC[v].data);
                end
            end
        end

        // R1 R5 R6 executed commands in order
        wait_exec(2);
        check("R6 exec count", 32'(exec_n), 32'd2);
        check("R1 first cpu", {24'b0, log_cpu[0]}, 32'd0);
        check("R1 first op", {30'b0, log_op[0]}, 32'd2);
        check("R1 first addr", log_addr[0], 32'h1000);
        check("R1 first size", log_size[0], 32'h80);
        check("R5 second whole", {31'b0, log_whole[1]}, 32'h1);
        check("R5 second addr", log_addr[1], 32'h0);
        check("R5 second size", log_size[1], 32'h0);
        check("R6 second cpu", {24'b0, log_cpu[1]}, 32'd1);

        // R7 R8 completion flags
        rd_reg(2'd0, S_DONE, rd); check("R7 done cpu0", rd, 32'h4);
        rd_reg(2'd1, S_DONE, rd); check("R7 done cpu1", rd, 32'h4);
        rd_reg(2'd2, S_DONE, rd); check("R7 done cpu2", rd, 32'h0);
        wr_reg(2'd1, S_DONE, 32'h0);
        rd_reg(2'd1, S_DONE, rd); check("R8 zero write keeps", rd, 32'h4);
        wr_reg(2'd0, S_DONE, 32'h4);
        rd_reg(2'd0, S_DONE, rd); check("R8 cpu0 cleared", rd, 32'h0);
        rd_reg(2'd1, S_DONE, rd); check("R8 cpu1 untouched", rd, 32'h4);

        // R4 queue full, R6 spacing
        for (int i = 0; i < 6; i++) begin
            wr_reg(2'd2, S_MODE, 32'h0000_0002);
            wr_reg(2'd2, S_ADDR, 32'(i * 256));
            wr_reg(2'd2, S_SIZE, 32'h40);
            rd_reg(2'd2, S_REGST, rd);
            check((i < 5) ? "R4 accepted" : "R4 full flag", rd, (i < 5) ? 32'h0 : 32'h2);
        end
        wait_exec(7);
        repeat (3 * EXEC) @(negedge clk);
        check("R4 dropped entry not run", 32'(exec_n), 32'd7);
        for (int i = 0; i < 5; i++) begin
            check("R6 order addr", log_addr[2 + i], 32'(i * 256));
            if (i > 0) check("R6 spacing", 32'(log_cyc[2 + i] - log_cyc[1 + i]), 32'(EXEC + 1));
        end
        rd_reg(2'd2, S_DONE, rd); check("R7 no notify no flag", rd, 32'h0);

        // R9 drain barrier
        wr_reg(2'd3, S_MODE, 32'h0000_0000);
        wr_reg(2'd3, S_ADDR, 32'h40);
        wr_reg(2'd3, S_SIZE, 32'h40);
        rd_reg(2'd3, S_REGST, rd); check("R9 setup accepted", rd, 32'h0);
        wr_reg(2'd3, S_PRIM, 32'h8);
        n0 = exec_n;
        bus_op(1'b0, 2'd3, S_PRIM, 32'h0, rd, w);
        check("R9 read value", rd, 32'h8);
        check("R9 drained before return", 32'(exec_n), 32'(n0 + 1));
        check("R9 read stalled", {31'b0, (w > 10)}, 32'h1);

        wr_reg(2'd3, S_MODE, 32'h0000_0000);
        rd_reg(2'd3, S_REGST, rd); check("R9 second accepted", rd, 32'h0);
        wr_reg(2'd3, S_PRIM, 32'h9);
        n0 = exec_n;
        bus_op(1'b0, 2'd3, S_PRIM, 32'h0, rd, w);
        check("R9 other code no stall", 32'(w), 32'd0);
        check("R9 other code not drained", 32'(exec_n), 32'(n0));
        check("R9 other code value", rd, 32'h9);
        wait_exec(n0 + 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule